// File: doc/BRIEF.md
# Sleep-Plane and Power-Fail Reboot Controller

This controller sits in the always-powered resume well. It turns a requested system sleep state into two active-low power-plane controls. One plane is asserted only in suspend-to-RAM, so core power can be cut while memory keeps its charge. The other is asserted only in soft-off, where core and memory may both be cut.

The controller also watches the core power-good input. It tells a power-good-only dropout apart from a full power failure, in which the resume-well reset was asserted before power-good came back. After a dropout it always requests a reboot. After a full failure a policy input decides between rebooting and staying in soft-off until a wake request. A millisecond tick paces the power-good qualification. The same tick lets the block flag a power-good rise that comes too soon after the supplies became valid.

The state machine has six states:
- PWR_WAIT: waiting for power-good.
- PG_QUAL: power-good high, waiting for a qualifying tick.
- REBOOT: one cycle, emits the reboot pulse.
- WORKING
- SUSPEND: suspend-to-RAM.
- SOFT_OFF

The named transitions are:
- PWR_WAIT→PG_QUAL on power-good high.
- PG_QUAL→PWR_WAIT on power-good low.
- PG_QUAL→WORKING on a tick after a wake.
- PG_QUAL→REBOOT on a tick after a dropout, or after a full failure with policy 0.
- PG_QUAL→SOFT_OFF on a tick after a full failure with policy 1.
- REBOOT→WORKING, always.
- WORKING→PWR_WAIT on power-good loss.
- WORKING→SUSPEND and WORKING→SOFT_OFF on a request.
- SUSPEND→SOFT_OFF on a request.
- SUSPEND→PWR_WAIT and SOFT_OFF→PWR_WAIT on a wake request.

Resume reset forces PWR_WAIT and marks the pending event as a full failure.

Top module: `sleep_reboot_ctrl`

## Requirements
- R1: While `rsm_rst_n` is low, from the first clock edge on, both plane outputs are high, `reboot_req` is low and all three flags are clear.
- R2: In WORKING both plane outputs are high. A request with code 01 (suspend-to-RAM) taken in WORKING drives `plane_ram_n` low and leaves `plane_off_n` high.
- R3: In SOFT_OFF, `plane_off_n` is low and `plane_ram_n` is high. The two plane outputs are never low together.
- R4: Requests are sampled only when `req_go` is high. The codes are 00 working, 01 suspend-to-RAM and 10 soft-off; code 11 is ignored. Requests are ignored in PWR_WAIT, PG_QUAL and REBOOT, and a suspend-to-RAM request is ignored in SOFT_OFF. A working request taken in a sleep state reaches WORKING after qualification, with no reboot pulse.
- R5: Qualification ends only on an `ms_tick` seen while `pwr_good` is high in PG_QUAL. A loss of `pwr_good` before that tick returns the block to PWR_WAIT and produces no reboot.
- R6: A loss of `pwr_good` in WORKING that ends without resume reset sets `pg_fail` in the cycle after `pwr_good` returns. The block then requests a reboot whatever `loss_policy` is. A loss of `pwr_good` in a sleep state sets nothing.
- R7: After resume reset, the return of `pwr_good` sets `full_fail`. After qualification, `loss_policy`=0 gives a reboot pulse and WORKING, and `loss_policy`=1 gives SOFT_OFF with no pulse.
- R8: `reboot_req` is high for exactly one cycle: the cycle after the clock edge that sampled the qualifying tick.
- R9: A tick counter restarts at zero whenever `supply_ok` is low and saturates at QUAL_TICKS. A rising edge of `pwr_good` while the counter is below QUAL_TICKS (default 16) sets `early_pg`.
- R10: The flags are sticky. `flag_clr` clears `pg_fail` and `early_pg`, but a set in the same cycle wins. `full_fail` ignores `flag_clr` and is cleared only by resume reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Resume-well clock |
| rsm_rst_n | input | 1 | Resume-well reset, active low, synchronous |
| supply_ok | input | 1 | Supplies reported valid; starts the early-rise count |
| pwr_good | input | 1 | Core power-good |
| ms_tick | input | 1 | One-cycle millisecond tick |
| req_go | input | 1 | Strobe that samples `req_code` |
| req_code | input | 2 | Requested state: 00 working, 01 suspend-to-RAM, 10 soft-off |
| loss_policy | input | 1 | After a full failure: 0 reboots, 1 stays in soft-off |
| flag_clr | input | 1 | Clears `pg_fail` and `early_pg` |
| plane_ram_n | output | 1 | Active-low suspend-to-RAM plane control |
| plane_off_n | output | 1 | Active-low soft-off plane control |
| reboot_req | output | 1 | One-cycle reboot request |
| pg_fail | output | 1 | Sticky power-good dropout flag |
| full_fail | output | 1 | Sticky full power failure flag |
| early_pg | output | 1 | Sticky early power-good rise flag |

## Verification
Two functions can act on the same flag in one cycle: a status flag being set by a returning `pwr_good`, and software clearing it with `flag_clr`. The bench provokes this by raising `pwr_good` in the same cycle as `flag_clr`, both after a dropout and during an early rise. In both cases it expects the flag to stay set. Sweeps over the tick count before a rise, over the policy bit and over the dropout length are judged against counts and flag values that the bench works out itself. The bench counts reboot pulses at the falling clock edge.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [2:0] {
        ST_PWR_WAIT,
        ST_PG_QUAL,
        ST_REBOOT,
        ST_WORKING,
        ST_SUSPEND,
        ST_SOFT_OFF
    } srb_state_e;

    typedef enum logic [1:0] {
        CAUSE_WAKE,
        CAUSE_GLITCH,
        CAUSE_FULL
    } srb_cause_e;

    localparam logic [1:0] REQ_WORK = 2'b00;
    localparam logic [1:0] REQ_RAM  = 2'b01;
    localparam logic [1:0] REQ_OFF  = 2'b10;

endpackage

// File: rtl/srb_early_timer.sv
module srb_early_timer #(
    parameter int QUAL_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic pwr_good,
    input  logic ms_tick,
    output logic early_set
);
    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

    logic [CW-1:0] tick_cnt;
    logic          pg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            pg_q     <= 1'b0;
        end else begin
            pg_q <= pwr_good;
            if (!supply_ok) begin
                tick_cnt <= '0;
            end else if (ms_tick && tick_cnt != LIMIT) begin
                tick_cnt <= tick_cnt + CW'(1);
            end
        end
    end

    // a rise seen before the counter saturates is premature
    assign early_set = pwr_good & ~pg_q & (tick_cnt < LIMIT);

endmodule

// File: rtl/srb_fsm.sv
module srb_fsm
    import srb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       ms_tick,
    input  logic       req_go,
    input  logic [1:0] req_code,
    input  logic       loss_policy,
    output logic       set_pgfail,
    output logic       set_full,
    output logic       reboot_req,
    output logic       plane_ram_n,
    output logic       plane_off_n
);
    srb_state_e state, nxt_state;
    srb_cause_e cause, nxt_cause;

    // state register; resume reset means a full failure is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PWR_WAIT;
            cause <= CAUSE_FULL;
        end else begin
            state <= nxt_state;
            cause <= nxt_cause;
        end
    end

    always_comb begin
        nxt_state  = state;
        nxt_cause  = cause;
        set_pgfail = 1'b0;
        set_full   = 1'b0;
        unique case (state)
            ST_PWR_WAIT: begin
                if (pwr_good) begin
                    nxt_state  = ST_PG_QUAL;
                    set_pgfail = (cause == CAUSE_GLITCH);
                    set_full   = (cause == CAUSE_FULL);
                end
            end
            ST_PG_QUAL: begin
                if (!pwr_good) begin
                    nxt_state = ST_PWR_WAIT;
                end else if (ms_tick) begin
                    if (cause == CAUSE_WAKE)
                        nxt_state = ST_WORKING;
                    else if (cause == CAUSE_FULL && loss_policy)
                        nxt_state = ST_SOFT_OFF;
                    else
                        nxt_state = ST_REBOOT;
                end
            end
            ST_REBOOT: begin
                nxt_state = ST_WORKING;
            end
            ST_WORKING: begin
                if (!pwr_good) begin
                    nxt_state = ST_PWR_WAIT;
                    nxt_cause = CAUSE_GLITCH;
                end else if (req_go && req_code == REQ_RAM) begin
                    nxt_state = ST_SUSPEND;
                end else if (req_go && req_code == REQ_OFF) begin
                    nxt_state = ST_SOFT_OFF;
                end
            end
            ST_SUSPEND: begin
                if (req_go && req_code == REQ_WORK) begin
                    nxt_state = ST_PWR_WAIT;
                    nxt_cause = CAUSE_WAKE;
                end else if (req_go && req_code == REQ_OFF) begin
                    nxt_state = ST_SOFT_OFF;
                end
            end
            ST_SOFT_OFF: begin
                if (req_go && req_code == REQ_WORK) begin
                    nxt_state = ST_PWR_WAIT;
                    nxt_cause = CAUSE_WAKE;
                end
            end
            default: begin
                nxt_state = ST_PWR_WAIT;
                nxt_cause = CAUSE_FULL;
            end
        endcase
    end

    // outputs decoded from the registered state only
    always_comb begin
        plane_ram_n = 1'b1;
        plane_off_n = 1'b1;
        reboot_req  = 1'b0;
        unique case (state)
            ST_SUSPEND:  plane_ram_n = 1'b0;
            ST_SOFT_OFF: plane_off_n = 1'b0;
            ST_REBOOT:   reboot_req  = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/srb_flags.sv
module srb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pgfail,
    input  logic set_full,
    input  logic set_early,
    input  logic flag_clr,
    output logic pg_fail,
    output logic full_fail,
    output logic early_pg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_fail   <= 1'b0;
            full_fail <= 1'b0;
            early_pg  <= 1'b0;
        end else begin
            pg_fail   <= set_pgfail | (pg_fail & ~flag_clr);
            early_pg  <= set_early | (early_pg & ~flag_clr);
            full_fail <= set_full | full_fail;
        end
    end

endmodule

// File: rtl/sleep_reboot_ctrl.sv
module sleep_reboot_ctrl #(
    parameter int QUAL_TICKS = 16
) (
    input  logic       clk,
    input  logic       rsm_rst_n,
    input  logic       supply_ok,
    input  logic       pwr_good,
    input  logic       ms_tick,
    input  logic       req_go,
    input  logic [1:0] req_code,
    input  logic       loss_policy,
    input  logic       flag_clr,
    output logic       plane_ram_n,
    output logic       plane_off_n,
    output logic       reboot_req,
    output logic       pg_fail,
    output logic       full_fail,
    output logic       early_pg
);
    logic set_pgfail;
    logic set_full;
    logic set_early;

    srb_early_timer #(.QUAL_TICKS(QUAL_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rsm_rst_n),
        .supply_ok (supply_ok),
        .pwr_good  (pwr_good),
        .ms_tick   (ms_tick),
        .early_set (set_early)
    );

    srb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rsm_rst_n),
        .pwr_good    (pwr_good),
        .ms_tick     (ms_tick),
        .req_go      (req_go),
        .req_code    (req_code),
        .loss_policy (loss_policy),
        .set_pgfail  (set_pgfail),
        .set_full    (set_full),
        .reboot_req  (reboot_req),
        .plane_ram_n (plane_ram_n),
        .plane_off_n (plane_off_n)
    );

    srb_flags u_flags (
        .clk        (clk),
        .rst_n      (rsm_rst_n),
        .set_pgfail (set_pgfail),
        .set_full   (set_full),
        .set_early  (set_early),
        .flag_clr   (flag_clr),
        .pg_fail    (pg_fail),
        .full_fail  (full_fail),
        .early_pg   (early_pg)
    );

endmodule

// File: rtl/sleep_reboot_chk.sv
module sleep_reboot_chk (
    input logic clk,
    input logic rsm_rst_n,
    input logic pwr_good,
    input logic ms_tick,
    input logic plane_ram_n,
    input logic plane_off_n,
    input logic reboot_req,
    input logic pg_fail,
    input logic full_fail,
    input logic early_pg
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rsm_rst_n |=> (plane_ram_n && plane_off_n && !reboot_req
                        && !pg_fail && !full_fail && !early_pg));

    p_planes_excl_r3: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        !(!plane_ram_n && !plane_off_n));

    p_reboot_single_r8: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        reboot_req |=> !reboot_req);

    p_reboot_after_tick_r8: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        reboot_req |-> ($past(ms_tick) && $past(pwr_good)));

    p_pgfail_on_return_r6: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $rose(pg_fail) |-> $past(pwr_good));

    p_early_on_rise_r9: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $rose(early_pg) |-> $past(pwr_good));

    p_full_sticky_r10: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        full_fail |=> full_fail);

endmodule

bind sleep_reboot_ctrl sleep_reboot_chk u_chk (
    .clk         (clk),
    .rsm_rst_n   (rsm_rst_n),
    .pwr_good    (pwr_good),
    .ms_tick     (ms_tick),
    .plane_ram_n (plane_ram_n),
    .plane_off_n (plane_off_n),
    .reboot_req  (reboot_req),
    .pg_fail     (pg_fail),
    .full_fail   (full_fail),
    .early_pg    (early_pg)
);

// File: tb/sleep_reboot_ctrl_test.sv
`timescale 1ns/1ps
module sleep_reboot_ctrl_test;
    localparam int QT = 16;

    logic       clk = 1'b0;
    logic       rsm_rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       pwr_good = 1'b0;
    logic       ms_tick = 1'b0;
    logic       req_go = 1'b0;
    logic [1:0] req_code = 2'b00;
    logic       loss_policy = 1'b0;
    logic       flag_clr = 1'b0;
    logic       plane_ram_n, plane_off_n, reboot_req;
    logic       pg_fail, full_fail, early_pg;

    int checks = 0;
    int errors = 0;
    int rb_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sleep_reboot_ctrl #(.QUAL_TICKS(QT)) uut (
        .clk(clk), .rsm_rst_n(rsm_rst_n), .supply_ok(supply_ok),
        .pwr_good(pwr_good), .ms_tick(ms_tick), .req_go(req_go),
        .req_code(req_code), .loss_policy(loss_policy), .flag_clr(flag_clr),
        .plane_ram_n(plane_ram_n), .plane_off_n(plane_off_n),
        .reboot_req(reboot_req), .pg_fail(pg_fail), .full_fail(full_fail),
        .early_pg(early_pg)
    );

    always @(negedge clk) if (reboot_req === 1'b1) rb_cnt <= rb_cnt + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic go(input logic [1:0] code);
        req_code = code;
        req_go = 1'b1;
        @(negedge clk);
        req_go = 1'b0;
    endtask

    task automatic do_reset();
        rsm_rst_n = 1'b0;
        pwr_good = 1'b0;
        supply_ok = 1'b0;
        cyc(3);
        rsm_rst_n = 1'b1;
        cyc(1);
    endtask

    // supplies valid, counter saturated, power-good up, qualifying tick
    task automatic bring_up(input logic pol);
        loss_policy = pol;
        supply_ok = 1'b1;
        repeat (QT) tick();
        pwr_good = 1'b1;
        cyc(2);
        tick();
        cyc(1);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        cyc(200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            report();
        end
    end

    initial begin
        int base;
        // R1 reset state
        cyc(3);
        check("R1 ram_n in reset", plane_ram_n, 1);
        check("R1 off_n in reset", plane_off_n, 1);
        check("R1 reboot in reset", reboot_req, 0);
        check("R1 flags in reset", {pg_fail, full_fail, early_pg}, 0);
        rsm_rst_n = 1'b1;
        cyc(1);

        // R9 sweep of tick counts before the power-good rise
        for (int k = 0; k <= QT + 4; k++) begin
            do_reset();
            supply_ok = 1'b1;
            repeat (k) tick();
            pwr_good = 1'b1;
            cyc(2);
            check($sformatf("R9 early after %0d ticks", k), early_pg, (k < QT) ? 1 : 0);
        end
        // R9 counter restarts when supplies drop
        do_reset();
        supply_ok = 1'b1;
        repeat (QT + 2) tick();
        supply_ok = 1'b0;
        cyc(1);
        supply_ok = 1'b1;
        repeat (3) tick();
        pwr_good = 1'b1;
        cyc(2);
        check("R9 early after supply restart", early_pg, 1);
        // R10 early set and clear in the same cycle
        do_reset();
        supply_ok = 1'b1;
        repeat (2) tick();
        pwr_good = 1'b1;
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        cyc(1);
        check("R10 early set beats clear", early_pg, 1);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        cyc(1);
        check("R10 early cleared", early_pg, 0);

        // R7 full failure for each policy
        for (int p = 0; p < 2; p++) begin
            do_reset();
            base = rb_cnt;
            bring_up(p[0]);
            cyc(2);
            check($sformatf("R7 reboots pol=%0d", p), rb_cnt - base, (p == 0) ? 1 : 0);
            check($sformatf("R7 full flag pol=%0d", p), full_fail, 1);
            check($sformatf("R7 pg_fail clear pol=%0d", p), pg_fail, 0);
            check($sformatf("R7 off plane pol=%0d", p), plane_off_n, (p == 0) ? 1 : 0);
            check($sformatf("R3 ram plane pol=%0d", p), plane_ram_n, 1);
        end
        // R4 wake from soft-off: qualify, no reboot
        base = rb_cnt;
        go(2'b00);
        cyc(2);
        tick();
        cyc(2);
        check("R4 wake planes", {plane_ram_n, plane_off_n}, 3);
        check("R4 wake no reboot", rb_cnt - base, 0);

        // R8 pulse timing and R5 qualification drop
        do_reset();
        loss_policy = 1'b0;
        supply_ok = 1'b1;
        repeat (QT) tick();
        pwr_good = 1'b1;
        cyc(2);
        pwr_good = 1'b0;
        cyc(2);
        base = rb_cnt;
        tick();
        cyc(2);
        check("R5 no reboot after drop", rb_cnt - base, 0);
        pwr_good = 1'b1;
        cyc(2);
        check("R5 no reboot before tick", rb_cnt - base, 0);
        tick();
        check("R8 pulse after tick", reboot_req, 1);
        cyc(1);
        check("R8 pulse one cycle", reboot_req, 0);
        check("R8 one pulse", rb_cnt - base, 1);
        check("R2 working planes", {plane_ram_n, plane_off_n}, 3);

        // R6 dropouts: policy and dropout length sweep
        for (int p = 0; p < 2; p++) begin
            for (int d = 1; d <= 3; d += 2) begin
                loss_policy = p[0];
                base = rb_cnt;
                pwr_good = 1'b0;
                cyc(d);
                pwr_good = 1'b1;
                cyc(2);
                check($sformatf("R6 pg_fail p=%0d d=%0d", p, d), pg_fail, 1);
                tick();
                check($sformatf("R6 reboot p=%0d d=%0d", p, d), reboot_req, 1);
                cyc(2);
                check($sformatf("R6 pulses p=%0d d=%0d", p, d), rb_cnt - base, 1);
                flag_clr = 1'b1;
                cyc(1);
                flag_clr = 1'b0;
                cyc(1);
                check("R10 pg_fail cleared", pg_fail, 0);
                check("R10 full ignores clear", full_fail, 1);
            end
        end
        // R10 dropout return with clear in the same cycle
        pwr_good = 1'b0;
        cyc(1);
        pwr_good = 1'b1;
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        cyc(1);
        check("R10 pg_fail set beats clear", pg_fail, 1);
        tick();
        cyc(1);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        cyc(1);

        // R2/R3/R4 sleep requests from working
        go(2'b11);
        check("R4 reserved ignored", {plane_ram_n, plane_off_n}, 3);
        go(2'b01);
        check("R2 suspend planes", {plane_ram_n, plane_off_n}, 1);
        pwr_good = 1'b0;
        cyc(3);
        pwr_good = 1'b1;
        cyc(2);
        check("R6 sleep dropout ignored", pg_fail, 0);
        check("R6 still suspended", {plane_ram_n, plane_off_n}, 1);
        go(2'b10);
        check("R3 soft-off planes", {plane_ram_n, plane_off_n}, 2);
        go(2'b01);
        check("R4 ram ignored in soft-off", {plane_ram_n, plane_off_n}, 2);
        base = rb_cnt;
        go(2'b00);
        cyc(2);
        tick();
        cyc(1);
        check("R4 woke to working", {plane_ram_n, plane_off_n}, 3);
        check("R4 wake without reboot", rb_cnt - base, 0);

        // R4 requests ignored while waiting for power-good
        do_reset();
        go(2'b01);
        check("R4 request ignored in wait", {plane_ram_n, plane_off_n}, 3);

        // R7 dropout then resume reset before the return
        do_reset();
        bring_up(1'b0);
        pwr_good = 1'b0;
        cyc(2);
        rsm_rst_n = 1'b0;
        cyc(2);
        rsm_rst_n = 1'b1;
        loss_policy = 1'b1;
        base = rb_cnt;
        supply_ok = 1'b1;
        repeat (QT) tick();
        pwr_good = 1'b1;
        cyc(2);
        tick();
        cyc(2);
        check("R7 reset makes full failure", full_fail, 1);
        check("R7 not a dropout", pg_fail, 0);
        check("R7 policy one no reboot", rb_cnt - base, 0);
        check("R7 policy one soft-off", plane_off_n, 0);

        done = 1'b1;
        report();
    end
endmodule